// File: doc/BRIEF.md
# Alarm Comparator with Status Flags

This block stores a calendar alarm point in BCD (hours, minutes, days, months; 24 bits in all). It compares that alarm with the running time counter once per minute. The comparison is not made at the minute edge. It is made a fixed number of slow time-base ticks after the edge, so the time counter has settled. An equal result sets a sticky alarm flag, and a dedicated output pin follows that flag. A date-mask flag narrows the comparison to hours and minutes only.

The block also keeps a sticky power-fail flag. Two configuration pins choose where the fail indication comes from:

- an internal low-voltage detect input,
- an external fail pin,
- a test setting that freezes the flag,
- a setting that ignores power fail completely.

The bus interface drives single-cycle command strobes. These strobes clear the alarm flag, set or clear the date mask, and report a write that used execute address. That write is the only event that clears the power-fail flag.

Packed layout of `time_now` and `alarm_q`:

- hours: bits [23:18]
- minutes: bits [17:11]
- days: bits [10:5]
- months: bits [4:0]

Top module: `alarm_flags`

## Requirements
- R1: After reset, `comp_flag`, `comp_pin`, `noda_flag`, `noda_defined` and `powf_flag` are 0, and `alarm_q` is 0.
- R2: When `alm_we` is high, one field is written from the low bits of `alm_wdata` and the rest of the byte is discarded. The fields are selected by `alm_sel` as follows:
  - 0 writes hours, [23:18], from data bits [5:0].
  - 1 writes minutes, [17:11], from data bits [6:0].
  - 2 writes days, [10:5], from data bits [5:0].
  - 3 writes months, [4:0], from data bits [4:0].
- R3: A `min_fall` pulse starts a delay of DELAY_TICKS ticks. Only cycles with `tick` high count. In the clock edge that sees the last of those ticks, `comp_flag` is set if the alarm equals `time_now` in that cycle. At no other time is the comparison made.
- R4: While `noda_flag` is 1, only bits [23:11] (hours and minutes) are compared. While it is 0, all 24 bits are compared.
- R5: `comp_flag` stays set until `cmd_clr_comp` is seen. A clear that arrives in the cycle right after the flag is set takes effect. When a match and a clear occur in the same cycle, the flag ends up set.
- R6: `comp_pin` always equals `comp_flag`.
- R7: `cmd_set_noda` sets `noda_flag` and `cmd_clr_noda` clears it. If both arrive in the same cycle, the set wins. Either command sets `noda_defined`, and `noda_defined` then stays 1 until reset.
- R8: The fail condition is selected by {`extpf`,`pfin`}:
  - 00: the fail condition is `lvd`.
  - 10: fail is always present (an external pin held low means fail).
  - 11: there is never a fail.

  A fail condition sets `powf_flag` at the next clock edge.
- R9: With {`extpf`,`pfin`} = 01 (test setting), `powf_flag` does not change unless `cmd_exec_wr` clears it.
- R10: `powf_flag` is cleared only by `cmd_exec_wr`. If a fail condition is present in the same cycle, the flag stays set.
- R11: A `min_fall` pulse that arrives while a delay is running restarts the delay from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base enable that paces the post-edge delay |
| min_fall | input | 1 | One-cycle pulse at the falling edge of the minute signal |
| time_now | input | 24 | Current time counter, packed BCD |
| alm_we | input | 1 | Alarm field write strobe |
| alm_sel | input | 2 | Alarm field select |
| alm_wdata | input | 8 | Alarm field write data, BCD |
| cmd_clr_comp | input | 1 | Clear the alarm-match flag |
| cmd_set_noda | input | 1 | Set the date-mask flag |
| cmd_clr_noda | input | 1 | Clear the date-mask flag |
| cmd_exec_wr | input | 1 | A data write using execute address was received |
| pfin | input | 1 | External power-fail pin (low means fail) |
| extpf | input | 1 | Power-fail source select pin |
| lvd | input | 1 | Internal low-voltage detect (high means fail) |
| alarm_q | output | 24 | Stored alarm, packed BCD |
| comp_flag | output | 1 | Sticky alarm-match flag |
| comp_pin | output | 1 | Alarm output pin |
| noda_flag | output | 1 | Date-mask flag |
| noda_defined | output | 1 | High once a date-mask command has been received |
| powf_flag | output | 1 | Sticky power-fail flag |

## Verification
The bench sweeps alarm points against times that match, or differ in exactly one field, with the date mask both on and off. This catches a design that masks the wrong bits: it would either miss an hours/minutes match or fire on a day-only difference.

Several delay cases are checked:

- The flag is sampled one tick before the delay ends and again at its end, so an off-by-one counter shows up as an early or late flag.
- A gapped tick stream exposes a counter that counts clocks instead of ticks.
- A second minute pulse arriving mid-delay must push the match out; a design that ignores it fires early.

All eight power-select combinations are swept. This catches a swapped table row, a test setting that sets or drops the flag, and a clear that beats a fail that is still present.

// File: rtl/alarm_flags.sv
module alarm_flags #(
  parameter int DELAY_TICKS = 131
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        min_fall,
  input  logic [23:0] time_now,
  input  logic        alm_we,
  input  logic [1:0]  alm_sel,
  input  logic [7:0]  alm_wdata,
  input  logic        cmd_clr_comp,
  input  logic        cmd_set_noda,
  input  logic        cmd_clr_noda,
  input  logic        cmd_exec_wr,
  input  logic        pfin,
  input  logic        extpf,
  input  logic        lvd,
  output logic [23:0] alarm_q,
  output logic        comp_flag,
  output logic        comp_pin,
  output logic        noda_flag,
  output logic        noda_defined,
  output logic        powf_flag
);

  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);
  localparam int TW = 24;
  localparam int HM_LO = 11;

  logic [TW-1:0] alarm;
  logic [CW-1:0] cnt;
  logic          pending;
  logic          fire;
  logic          match;
  logic          pf_fail;
  logic          pf_test;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= '0;
    end else if (alm_we) begin
      case (alm_sel)
        2'd0:    alarm[23:18] <= alm_wdata[5:0];
        2'd1:    alarm[17:11] <= alm_wdata[6:0];
        2'd2:    alarm[10:5]  <= alm_wdata[5:0];
        default: alarm[4:0]   <= alm_wdata[4:0];
      endcase
    end
  end

  assign alarm_q = alarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (min_fall) begin
      pending <= 1'b1;
      cnt     <= '0;
    end else if (pending && tick) begin
      if (cnt == LAST) begin
        pending <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign fire  = pending && tick && (cnt == LAST) && !min_fall;
  assign match = noda_flag ? (alarm[TW-1:HM_LO] == time_now[TW-1:HM_LO])
                           : (alarm == time_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 comp_flag <= 1'b0;
    else if (fire && match)     comp_flag <= 1'b1;
    else if (cmd_clr_comp)      comp_flag <= 1'b0;
  end

  assign comp_pin = comp_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      noda_flag    <= 1'b0;
      noda_defined <= 1'b0;
    end else begin
      if (cmd_set_noda)      noda_flag <= 1'b1;
      else if (cmd_clr_noda) noda_flag <= 1'b0;
      if (cmd_set_noda || cmd_clr_noda) noda_defined <= 1'b1;
    end
  end

  always_comb begin
    case ({extpf, pfin})
      2'b00:   pf_fail = lvd;
      2'b10:   pf_fail = 1'b1;
      default: pf_fail = 1'b0;
    endcase
  end

  assign pf_test = !extpf && pfin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            powf_flag <= 1'b0;
    else if (pf_fail)      powf_flag <= 1'b1;
    else if (cmd_exec_wr)  powf_flag <= 1'b0;
  end

  AST_COMP_RISE_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_flag) |-> $past(fire)); // R3
  AST_COMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !cmd_clr_comp) |=> $stable(comp_flag)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R11
  AST_NODA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_set_noda && !cmd_clr_noda) |=> $stable(noda_flag)); // R7
  AST_NODA_DEF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    noda_defined |=> noda_defined); // R7
  AST_POWF_EXT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (extpf && !pfin) |=> powf_flag); // R8
  AST_POWF_TEST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_test && !cmd_exec_wr) |=> $stable(powf_flag)); // R9
  AST_POWF_CLEAR_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powf_flag) |-> $past(cmd_exec_wr)); // R10

endmodule

// File: tb/tb_alarm_flags.sv
module tb_alarm_flags;
  localparam int DLY = 131;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, min_fall = 0, alm_we = 0;
  logic [23:0] time_now = '0;
  logic [1:0] alm_sel = '0;
  logic [7:0] alm_wdata = '0;
  logic cmd_clr_comp = 0, cmd_set_noda = 0, cmd_clr_noda = 0, cmd_exec_wr = 0;
  logic pfin = 1, extpf = 1, lvd = 0;
  logic [23:0] alarm_q;
  logic comp_flag, comp_pin, noda_flag, noda_defined, powf_flag;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  alarm_flags #(.DELAY_TICKS(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .min_fall(min_fall), .time_now(time_now),
    .alm_we(alm_we), .alm_sel(alm_sel), .alm_wdata(alm_wdata),
    .cmd_clr_comp(cmd_clr_comp), .cmd_set_noda(cmd_set_noda), .cmd_clr_noda(cmd_clr_noda),
    .cmd_exec_wr(cmd_exec_wr), .pfin(pfin), .extpf(extpf), .lvd(lvd),
    .alarm_q(alarm_q), .comp_flag(comp_flag), .comp_pin(comp_pin),
    .noda_flag(noda_flag), .noda_defined(noda_defined), .powf_flag(powf_flag));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [23:0] pack(input int h, input int m, input int d, input int mo);
    logic [7:0] bh, bm, bd, bmo;
    bh = bcd(h); bm = bcd(m); bd = bcd(d); bmo = bcd(mo);
    return {bh[5:0], bm[6:0], bd[5:0], bmo[4:0]};
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    alm_we = 1; alm_sel = sel; alm_wdata = d; step(); alm_we = 0;
  endtask

  task automatic set_alarm(input int h, input int m, input int d, input int mo);
    wr(2'd0, bcd(h)); wr(2'd1, bcd(m)); wr(2'd2, bcd(d)); wr(2'd3, bcd(mo));
  endtask

  task automatic minute_pulse();
    min_fall = 1; tick = 0; step(); min_fall = 0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1; repeat (n) step(); tick = 0;
  endtask

  task automatic clr_comp();
    cmd_clr_comp = 1; step(); cmd_clr_comp = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 comp", comp_flag, 0); chk("R1 pin", comp_pin, 0);
    chk("R1 noda", noda_flag, 0); chk("R1 noda_def", noda_defined, 0);
    chk("R1 powf", powf_flag, 0); chk("R1 alarm", alarm_q, 0);

    // R2 field placement and discarded upper bits
    wr(2'd0, 8'hFF); chk("R2 hours", alarm_q, 24'h3F << 18);
    wr(2'd1, 8'hFF); chk("R2 minutes", alarm_q, (24'h3F << 18) | (24'h7F << 11));
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); chk("R2 all", alarm_q, 24'hFFFFFF);
    set_alarm(12, 34, 5, 6); chk("R2 bcd", alarm_q, pack(12, 34, 5, 6));

    // R3/R4 sweep: equal or one field different, mask on and off
    for (int i = 0; i < 24; i++) begin
      int h, m, d, mo, th, tm, td, tmo, fld;
      logic nd, exp_m;
      h = i; m = (i * 7) % 60; d = 1 + (i % 28); mo = 1 + (i % 12);
      fld = i % 5; nd = (i / 5) % 2;
      th = h; tm = m; td = d; tmo = mo;
      if (fld == 1) th = (h + 1) % 24;
      if (fld == 2) tm = (m + 1) % 60;
      if (fld == 3) td = (d % 28) + 1;
      if (fld == 4) tmo = (mo % 12) + 1;
      if (nd) begin cmd_set_noda = 1; step(); cmd_set_noda = 0; end
      else begin cmd_clr_noda = 1; step(); cmd_clr_noda = 0; end
      set_alarm(h, m, d, mo);
      time_now = pack(th, tm, td, tmo);
      exp_m = nd ? (th == h && tm == m) : (th == h && tm == m && td == d && tmo == mo);
      minute_pulse();
      run_ticks(DLY - 1);
      chk("R3 not before delay", comp_flag, 0);
      run_ticks(1);
      chk(nd ? "R4 masked compare" : "R3 full compare", comp_flag, exp_m);
      chk("R6 pin", comp_pin, exp_m);
      clr_comp();
      chk("R5 clear right after set", comp_flag, 0);
    end

    // R3 only ticks count: gapped ticks
    cmd_clr_noda = 1; step(); cmd_clr_noda = 0;
    set_alarm(1, 2, 3, 4); time_now = pack(1, 2, 3, 4);
    minute_pulse();
    for (int k = 0; k < DLY - 1; k++) begin tick = 1; step(); tick = 0; step(); end
    chk("R3 gapped ticks early", comp_flag, 0);
    tick = 1; step(); tick = 0;
    chk("R3 gapped ticks fire", comp_flag, 1);
    step(); step();
    chk("R5 latched", comp_flag, 1);
    clr_comp();

    // R5 clear and match in same cycle: set wins
    minute_pulse();
    run_ticks(DLY - 1);
    tick = 1; cmd_clr_comp = 1; step(); tick = 0; cmd_clr_comp = 0;
    chk("R5 set beats clear", comp_flag, 1);
    clr_comp();

    // R11 restart mid-delay
    minute_pulse();
    run_ticks(100);
    minute_pulse();
    run_ticks(DLY - 1);
    chk("R11 restarted not yet", comp_flag, 0);
    run_ticks(1);
    chk("R11 restarted fire", comp_flag, 1);
    clr_comp();

    // R7 noda commands
    cmd_set_noda = 1; cmd_clr_noda = 1; step(); cmd_set_noda = 0; cmd_clr_noda = 0;
    chk("R7 set wins", noda_flag, 1); chk("R7 defined", noda_defined, 1);
    cmd_clr_noda = 1; step(); cmd_clr_noda = 0;
    chk("R7 clear", noda_flag, 0); step();
    chk("R7 defined sticky", noda_defined, 1);

    // R8/R9/R10 full power-select sweep
    for (int c = 0; c < 8; c++) begin
      logic ep, pi, lv, fail, tst, start;
      ep = c[2]; pi = c[1]; lv = c[0];
      fail = (!ep && !pi) ? lv : (ep && !pi);
      tst = !ep && pi;
      for (int s = 0; s < 2; s++) begin
        start = s[0];
        extpf = 1; pfin = 1; lvd = 0;
        cmd_exec_wr = 1; step(); cmd_exec_wr = 0;
        if (start) begin extpf = 1; pfin = 0; step(); extpf = 1; pfin = 1; end
        extpf = ep; pfin = pi; lvd = lv; step();
        if (tst) chk("R9 test freeze", powf_flag, start);
        else chk("R8 source select", powf_flag, fail | start);
        cmd_exec_wr = 1; step(); cmd_exec_wr = 0;
        chk("R10 exec clear vs fail", powf_flag, fail);
      end
    end
    extpf = 1; pfin = 0; step(); extpf = 1; pfin = 1; step(); step();
    chk("R10 latched after recovery", powf_flag, 1);
    cmd_exec_wr = 1; step(); cmd_exec_wr = 0;
    chk("R10 exec clears", powf_flag, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule